// File: doc/BRIEF.md
# Two-Bus Compare-and-Sort Controller

This block takes two unsigned operands and leaves the smaller one in a low-side register and the larger one in a high-side register. Both operands share two internal buses. The low-side register can take data only from bus one, and the high-side register only from bus two. A magnitude comparator watches the two buses and reports whether bus one holds the greater value.

A one-hot Moore controller drives the operands onto the buses. It first places the operands in their natural order and compares them. In the next cycle it routes them so that the smaller one lands on bus one, and it pulses both load enables together. The per-bus drive enables are active-low and appear at the ports, along with the two load strobes and the stored results.

A sort is started by a one-cycle request in the idle state. The sorted results are visible three clock edges after the request is sampled.

Top module: `sort_pair_ctrl`

## Requirements
- R1: After reset all four drive enables are high (no source on any bus), both load strobes are low and both result registers read 0.
- R2: While idle with `start` low, no bus is driven, the load strobes stay low and the result registers hold their values, even if the operands change.
- R3: The cycle after `start` is sampled high in idle is the compare cycle. In that cycle `op_a` drives bus one (`a_bus1_n`=0), `op_b` drives bus two (`b_bus2_n`=0), the other two enables are high and no load strobe is active.
- R4: When `op_a` > `op_b` in the compare cycle, the next cycle drives `op_b` on bus one and `op_a` on bus two (`b_bus1_n`=0, `a_bus2_n`=0), with both `load_lo` and `load_hi` high.
- R5: When `op_a` <= `op_b` in the compare cycle (equality included), the next cycle drives `op_a` on bus one and `op_b` on bus two, with both load strobes high.
- R6: One cycle after the load cycle, `lo_val` holds the smaller operand and `hi_val` the larger one. The controller is then back in idle with all drive enables high.
- R7: In every cycle at most one source drives each bus, and the two load strobes are always asserted together.
- R8: `start` has no effect during the compare and load cycles. A sort always takes exactly three cycles from the request to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sort request, sampled in idle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| a_bus1_n | output | 1 | `op_a` onto bus one, active low |
| b_bus1_n | output | 1 | `op_b` onto bus one, active low |
| a_bus2_n | output | 1 | `op_a` onto bus two, active low |
| b_bus2_n | output | 1 | `op_b` onto bus two, active low |
| load_lo | output | 1 | Load strobe of the low-side register |
| load_hi | output | 1 | Load strobe of the high-side register |
| lo_val | output | W | Low-side register contents |
| hi_val | output | W | High-side register contents |

## Verification
The results are due on a fixed schedule, counted in edges after the edge that samples `start`:
- the compare-cycle bus enables appear after one edge;
- the routed enables and load strobes appear after two edges;
- the sorted register values and the return to idle appear after three edges.

The bench drives every input on a falling edge and samples each result on the falling edge that follows the edge at which it is due. Each sample therefore sees settled register outputs of exactly one state.

// File: rtl/sort_pkg.sv
package sort_pkg;
   localparam int ST_N    = 4;
   localparam int ST_IDLE = 0;
   localparam int ST_CMP  = 1;
   localparam int ST_AB   = 2;  // op_a to low side, op_b to high side
   localparam int ST_BA   = 3;  // op_b to low side, op_a to high side
   typedef logic [ST_N-1:0] sort_state_t;
   localparam sort_state_t ST_RESET = sort_state_t'(1) << ST_IDLE;
endpackage

// File: rtl/sort_fsm.sv
module sort_fsm
   import sort_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic bus1_gt,
   output logic a_bus1_n,
   output logic b_bus1_n,
   output logic a_bus2_n,
   output logic b_bus2_n,
   output logic load
);
   sort_state_t st, st_nx;

   always_comb begin
      st_nx = '0;
      if (st[ST_IDLE]) begin
         if (start) st_nx[ST_CMP] = 1'b1;
         else       st_nx[ST_IDLE] = 1'b1;
      end
      if (st[ST_CMP]) begin
         if (bus1_gt) st_nx[ST_BA] = 1'b1;
         else         st_nx[ST_AB] = 1'b1;
      end
      if (st[ST_AB] || st[ST_BA]) st_nx[ST_IDLE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RESET;
      else        st <= st_nx;
   end

   assign a_bus1_n = ~(st[ST_CMP] | st[ST_AB]);
   assign b_bus2_n = ~(st[ST_CMP] | st[ST_AB]);
   assign b_bus1_n = ~st[ST_BA];
   assign a_bus2_n = ~st[ST_BA];
   assign load     = st[ST_AB] | st[ST_BA];
endmodule

// File: rtl/sort_bus.sv
module sort_bus #(
   parameter int W    = 4,
   parameter int NSRC = 2
) (
   input  logic [NSRC-1:0]        drv_n,
   input  logic [NSRC-1:0][W-1:0] src,
   output logic [W-1:0]           bus
);
   logic [NSRC-1:0][W-1:0] gated;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign gated[i] = drv_n[i] ? '0 : src[i];
      end
   endgenerate

   always_comb begin
      bus = '0;
      for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
   end
endmodule

// File: rtl/sort_reg.sv
module sort_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/sort_pair_ctrl.sv
module sort_pair_ctrl #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic         a_bus1_n,
   output logic         b_bus1_n,
   output logic         a_bus2_n,
   output logic         b_bus2_n,
   output logic         load_lo,
   output logic         load_hi,
   output logic [W-1:0] lo_val,
   output logic [W-1:0] hi_val
);
   localparam int NSRC = 2;

   initial begin
      if (W < 1) $error("sort_pair_ctrl: W must be at least 1");
   end

   logic [W-1:0] bus1, bus2;
   logic         bus1_gt, load;

   sort_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .bus1_gt(bus1_gt),
      .a_bus1_n(a_bus1_n), .b_bus1_n(b_bus1_n),
      .a_bus2_n(a_bus2_n), .b_bus2_n(b_bus2_n), .load(load)
   );

   sort_bus #(.W(W), .NSRC(NSRC)) u_bus1 (
      .drv_n({b_bus1_n, a_bus1_n}), .src({op_b, op_a}), .bus(bus1)
   );
   sort_bus #(.W(W), .NSRC(NSRC)) u_bus2 (
      .drv_n({b_bus2_n, a_bus2_n}), .src({op_b, op_a}), .bus(bus2)
   );

   assign bus1_gt = bus1 > bus2;
   assign load_lo = load;
   assign load_hi = load;

   sort_reg #(.W(W)) u_lo (.clk(clk), .rst_n(rst_n), .ld(load_lo), .d(bus1), .q(lo_val));
   sort_reg #(.W(W)) u_hi (.clk(clk), .rst_n(rst_n), .ld(load_hi), .d(bus2), .q(hi_val));
endmodule

// File: rtl/sort_pair_chk.sv
module sort_pair_chk #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         a_bus1_n,
   input logic         b_bus1_n,
   input logic         a_bus2_n,
   input logic         b_bus2_n,
   input logic         load_lo,
   input logic         load_hi,
   input logic [W-1:0] lo_val,
   input logic [W-1:0] hi_val
);
   logic idle_q;
   assign idle_q = a_bus1_n & b_bus1_n & a_bus2_n & b_bus2_n;

   assert_bus1_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~a_bus1_n, ~b_bus1_n}));
   assert_bus2_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~a_bus2_n, ~b_bus2_n}));
   assert_loads_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_lo == load_hi);
   assert_start_compare_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && start) |=> (!a_bus1_n && !b_bus2_n && !load_lo));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q && !start) |=> (idle_q && $stable(lo_val) && $stable(hi_val)));
   assert_ordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_lo |=> (lo_val <= hi_val && idle_q));
   assert_load_follows_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_bus1_n && !load_lo) |=> load_lo);
endmodule

bind sort_pair_ctrl sort_pair_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .a_bus1_n(a_bus1_n), .b_bus1_n(b_bus1_n),
   .a_bus2_n(a_bus2_n), .b_bus2_n(b_bus2_n),
   .load_lo(load_lo), .load_hi(load_hi),
   .lo_val(lo_val), .hi_val(hi_val)
);

// File: tb/tb_sort_pair_ctrl.sv
`timescale 1ns/1ps
module tb_sort_pair_ctrl;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         a_bus1_n, b_bus1_n, a_bus2_n, b_bus2_n, load_lo, load_hi;
   logic [W-1:0] lo_val, hi_val;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sort_pair_ctrl #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .a_bus1_n(a_bus1_n), .b_bus1_n(b_bus1_n),
      .a_bus2_n(a_bus2_n), .b_bus2_n(b_bus2_n),
      .load_lo(load_lo), .load_hi(load_hi), .lo_val(lo_val), .hi_val(hi_val)
   );

   function automatic logic [5:0] ctl();
      return {a_bus1_n, b_bus1_n, a_bus2_n, b_bus2_n, load_lo, load_hi};
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // controls {a1_n,b1_n,a2_n,b2_n,ld_lo,ld_hi}
   localparam logic [5:0] C_IDLE = 6'b1111_00;
   localparam logic [5:0] C_CMP  = 6'b0110_00;
   localparam logic [5:0] C_AB   = 6'b0110_11;
   localparam logic [5:0] C_BA   = 6'b1001_11;

   task automatic t_reset();
      chk("R1 controls", 16'(ctl()), 16'(C_IDLE));
      chk("R1 registers", {8'h0, lo_val, hi_val}, 16'h0);
   endtask

   task automatic t_sort(logic [W-1:0] a, logic [W-1:0] b);
      logic [W-1:0] mn, mx;
      mn = (a > b) ? b : a;
      mx = (a > b) ? a : b;
      @(negedge clk); op_a = a; op_b = b; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R3 compare", 16'(ctl()), 16'(C_CMP));
      @(negedge clk);
      if (a > b) chk("R4 route swap", 16'(ctl()), 16'(C_BA));
      else       chk("R5 route keep", 16'(ctl()), 16'(C_AB));
      @(negedge clk);
      chk("R6 min", 16'(lo_val), 16'(mn));
      chk("R6 max", 16'(hi_val), 16'(mx));
      chk("R6 idle", 16'(ctl()), 16'(C_IDLE));
   endtask

   task automatic t_hold();
      logic [W-1:0] l0, h0;
      l0 = lo_val; h0 = hi_val;
      @(negedge clk); op_a = 4'd1; op_b = 4'd14;
      repeat (3) @(negedge clk);
      chk("R2 idle controls", 16'(ctl()), 16'(C_IDLE));
      chk("R2 hold", {8'h0, lo_val, hi_val}, {8'h0, l0, h0});
   endtask

   task automatic t_busy_start();
      @(negedge clk); op_a = 4'd12; op_b = 4'd4; start = 1'b1;
      @(negedge clk);
      chk("R8 compare", 16'(ctl()), 16'(C_CMP));
      @(negedge clk);
      chk("R8 load", 16'(ctl()), 16'(C_BA));
      @(negedge clk);
      chk("R8 back to idle", 16'(ctl()), 16'(C_IDLE));
      chk("R8 result", {8'h0, lo_val, hi_val}, {8'h0, 4'd4, 4'd12});
      start = 1'b0;
      @(negedge clk);
      chk("R8 stays idle", 16'(ctl()), 16'(C_IDLE));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sort(4'd6, 4'd2);
      t_sort(4'd3, 4'd5);
      t_sort(4'd7, 4'd7);
      t_sort(4'd0, 4'd15);
      t_sort(4'd15, 4'd0);
      t_hold();
      t_busy_start();
      t_sort(4'd9, 4'd8);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule